// File: doc/BRIEF.md
# Power-Down Acknowledge and Wake Request Sequencer

This block sits between an endpoint's link layer and the user application and sequences the two power-management messages the endpoint sends upstream. A turn-off notice from upstream arrives as a single-cycle pulse. The block then raises an active-low warning to the user. While that warning is out, it watches the user's active-low consent input. Once consent is seen, it asks the transmitter to send the acknowledge message. It holds that request until the transmitter accepts it, and then drops the warning.

The block also takes a one-cycle active-low wake pulse from the user and turns it into a request for one wake message upstream. Wake requests are only valid while the link state is stable. The block registers the link layer's state selector and drives it to the user as a 3-bit active-low one-hot code. Gating uses the same code it reports. A wake pulse that arrives while the code shows a transition is dropped and reported on an error pulse. Message formatting and link training are outside this block.

Top module: `pm_turnoff_hs`

## Requirements
- R1: In the cycle after synchronous reset, `to_turnoff_n_o` is 1, `ack_req_o`, `pme_req_o` and `wake_err_o` are 0, and `link_state_n_o` is 3'b111.
- R2: A cycle with `turnoff_msg_i` high while no acknowledge is in progress drives `to_turnoff_n_o` low from the next cycle.
- R3: `turnoff_ok_n_i` is sampled only while `to_turnoff_n_o` is low. The first such sampled cycle with it low raises `ack_req_o` in the next cycle. A consent held low before the warning therefore raises `ack_req_o` one cycle after the warning, not at the same time.
- R4: `ack_req_o` and the low `to_turnoff_n_o` both hold until a cycle with `ack_req_o` and `ack_accept_i` both high. In the next cycle `ack_req_o` is 0 and `to_turnoff_n_o` is 1.
- R5: `turnoff_msg_i` pulses that arrive while `to_turnoff_n_o` is low are ignored. After the pending acknowledge is accepted, the warning stays released.
- R6: `link_state_n_o` shows, one cycle late, the selector `link_sel_i`: 0 gives 3'b110 (L0), 1 gives 3'b101 (L0s), 2 gives 3'b011 (L1), and 3 gives 3'b111 (in transition).
- R7: A cycle with `wake_n_i` low while `link_state_n_o` is not 3'b111 raises `pme_req_o` from the next cycle. It stays high until a cycle with `pme_accept_i` high, and is 0 in the cycle after that.
- R8: A cycle with `wake_n_i` low while `link_state_n_o` is 3'b111 raises no message request. Instead, `wake_err_o` is high for exactly the next cycle.
- R9: A wake pulse while `pme_req_o` is already high adds no request. Once the pending one is accepted, `pme_req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| turnoff_msg_i | input | 1 | One-cycle pulse: turn-off notice received from upstream |
| turnoff_ok_n_i | input | 1 | User consent to power removal, active low |
| to_turnoff_n_o | output | 1 | Warning to user that power removal is pending, active low |
| ack_req_o | output | 1 | Request to transmit the acknowledge message |
| ack_accept_i | input | 1 | Transmitter accepts the acknowledge request |
| wake_n_i | input | 1 | One-cycle wake pulse from user, active low |
| pme_req_o | output | 1 | Request to transmit a wake message |
| pme_accept_i | input | 1 | Transmitter accepts the wake request |
| wake_err_o | output | 1 | One-cycle pulse: wake dropped during a link transition |
| link_sel_i | input | 2 | Link state selector from the link layer (0 L0, 1 L0s, 2 L1, 3 transition) |
| link_state_n_o | output | 3 | Reported link state, active-low one-hot, 3'b111 in transition |

## Verification
Every output is a register, so each result is due exactly one clock edge after the input cycle that causes it. The warning follows the notice by one edge. The acknowledge request follows the first consent seen under the warning by one edge. Both release one edge after acceptance. The link code follows its selector by one edge, and the wake request or error pulse follows the wake cycle by one edge. The bench drives inputs on the falling edge and samples on the next falling edge after the edge under test. A wake pulse is always applied one edge after the selector changes, so gating uses the new code. The link encoding and wake gating come from a vector table. Directed sequences cover consent before the warning, stalled acceptance, repeated notices and repeated wakes.

// File: rtl/pmh_pkg.sv
package pmh_pkg;

    localparam int SEL_W  = 2;
    localparam int CODE_W = 3;

    typedef enum logic [SEL_W-1:0] {
        LNK_L0     = 2'd0,
        LNK_L0S    = 2'd1,
        LNK_L1     = 2'd2,
        LNK_MOVING = 2'd3
    } link_sel_e;

    typedef enum logic [1:0] {
        TO_IDLE   = 2'd0,
        TO_NOTIFY = 2'd1,
        TO_ACK    = 2'd2
    } toff_state_e;

    typedef struct packed {
        logic req;
        logic err;
    } wake_res_t;

    localparam logic [CODE_W-1:0] CODE_MOVING = 3'b111;

    function automatic logic [CODE_W-1:0] link_code(link_sel_e s);
        logic [CODE_W-1:0] c;
        case (s)
            LNK_L0:  c = 3'b110;
            LNK_L0S: c = 3'b101;
            LNK_L1:  c = 3'b011;
            default: c = CODE_MOVING;
        endcase
        return c;
    endfunction

    function automatic logic code_stable(logic [CODE_W-1:0] c);
        return $countones(c) == CODE_W - 1;
    endfunction

endpackage

// File: rtl/pmh_link_enc.sv
module pmh_link_enc
    import pmh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [CODE_W-1:0] code_o,
    output logic              stable_o
);
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) code_q <= CODE_MOVING;
        else     code_q <= link_code(link_sel_e'(sel_i));
    end

    assign code_o   = code_q;
    assign stable_o = code_stable(code_q);
endmodule

// File: rtl/pmh_toff_fsm.sv
module pmh_toff_fsm
    import pmh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic notice_i,
    input  logic consent_n_i,
    input  logic accept_i,
    output logic warn_n_o,
    output logic ack_req_o
);
    toff_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            TO_IDLE:   if (notice_i)     st_d = TO_NOTIFY;
            TO_NOTIFY: if (!consent_n_i) st_d = TO_ACK;
            TO_ACK:    if (accept_i)     st_d = TO_IDLE;
            default:                     st_d = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TO_IDLE;
        else     st_q <= st_d;
    end

    assign warn_n_o  = (st_q == TO_IDLE);
    assign ack_req_o = (st_q == TO_ACK);
endmodule

// File: rtl/pmh_wake_gate.sv
module pmh_wake_gate
    import pmh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wake_n_i,
    input  logic      stable_i,
    input  logic      accept_i,
    output wake_res_t res_o
);
    wake_res_t res_q, res_d;

    always_comb begin
        res_d.err = !wake_n_i && !stable_i;
        if (res_q.req)
            res_d.req = !accept_i;
        else
            res_d.req = !wake_n_i && stable_i;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign res_o = res_q;
endmodule

// File: rtl/pm_turnoff_hs.sv
module pm_turnoff_hs
    import pmh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              turnoff_msg_i,
    input  logic              turnoff_ok_n_i,
    output logic              to_turnoff_n_o,
    output logic              ack_req_o,
    input  logic              ack_accept_i,
    input  logic              wake_n_i,
    output logic              pme_req_o,
    input  logic              pme_accept_i,
    output logic              wake_err_o,
    input  logic [SEL_W-1:0]  link_sel_i,
    output logic [CODE_W-1:0] link_state_n_o
);
    logic      stable;
    wake_res_t wres;

    pmh_link_enc u_enc (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (link_sel_i),
        .code_o   (link_state_n_o),
        .stable_o (stable)
    );

    pmh_toff_fsm u_toff (
        .clk         (clk),
        .rst         (rst),
        .notice_i    (turnoff_msg_i),
        .consent_n_i (turnoff_ok_n_i),
        .accept_i    (ack_accept_i),
        .warn_n_o    (to_turnoff_n_o),
        .ack_req_o   (ack_req_o)
    );

    pmh_wake_gate u_wake (
        .clk      (clk),
        .rst      (rst),
        .wake_n_i (wake_n_i),
        .stable_i (stable),
        .accept_i (pme_accept_i),
        .res_o    (wres)
    );

    assign pme_req_o  = wres.req;
    assign wake_err_o = wres.err;
endmodule

// File: rtl/pm_turnoff_hs_chk.sv
module pm_turnoff_hs_chk (
    input logic       clk,
    input logic       rst,
    input logic       turnoff_ok_n_i,
    input logic       to_turnoff_n_o,
    input logic       ack_req_o,
    input logic       ack_accept_i,
    input logic       wake_n_i,
    input logic       pme_req_o,
    input logic       pme_accept_i,
    input logic       wake_err_o,
    input logic [2:0] link_state_n_o
);
    AST_ACK_UNDER_WARN: assert property (@(posedge clk) disable iff (rst)
        ack_req_o |-> !to_turnoff_n_o); // R4
    AST_ACK_NEEDS_OK: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_req_o) |-> ($past(!turnoff_ok_n_i) && $past(!to_turnoff_n_o))); // R3
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_req_o && !ack_accept_i) |=> ack_req_o); // R4
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ack_req_o && ack_accept_i) |=> (to_turnoff_n_o && !ack_req_o)); // R4
    AST_LINK_CODE: assert property (@(posedge clk) disable iff (rst)
        $countones(link_state_n_o) >= 2); // R6
    AST_WAKE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wake_n_i && !pme_req_o && link_state_n_o != 3'b111) |=> (pme_req_o && !wake_err_o)); // R7
    AST_WAKE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (!wake_n_i && !pme_req_o && link_state_n_o == 3'b111) |=> (wake_err_o && !pme_req_o)); // R8
    AST_PME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pme_req_o && !pme_accept_i) |=> pme_req_o); // R7
    AST_PME_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (pme_req_o && pme_accept_i) |=> !pme_req_o); // R9
endmodule

bind pm_turnoff_hs pm_turnoff_hs_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .turnoff_ok_n_i (turnoff_ok_n_i),
    .to_turnoff_n_o (to_turnoff_n_o),
    .ack_req_o      (ack_req_o),
    .ack_accept_i   (ack_accept_i),
    .wake_n_i       (wake_n_i),
    .pme_req_o      (pme_req_o),
    .pme_accept_i   (pme_accept_i),
    .wake_err_o     (wake_err_o),
    .link_state_n_o (link_state_n_o)
);

// File: tb/test_pm_turnoff_hs.sv
module test_pm_turnoff_hs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       turnoff_msg_i = 1'b0;
    logic       turnoff_ok_n_i = 1'b1;
    logic       to_turnoff_n_o;
    logic       ack_req_o;
    logic       ack_accept_i = 1'b0;
    logic       wake_n_i = 1'b1;
    logic       pme_req_o;
    logic       pme_accept_i = 1'b0;
    logic       wake_err_o;
    logic [1:0] link_sel_i = 2'd3;
    logic [2:0] link_state_n_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    pm_turnoff_hs i_pm_turnoff_hs (
        .clk            (clk),
        .rst            (rst),
        .turnoff_msg_i  (turnoff_msg_i),
        .turnoff_ok_n_i (turnoff_ok_n_i),
        .to_turnoff_n_o (to_turnoff_n_o),
        .ack_req_o      (ack_req_o),
        .ack_accept_i   (ack_accept_i),
        .wake_n_i       (wake_n_i),
        .pme_req_o      (pme_req_o),
        .pme_accept_i   (pme_accept_i),
        .wake_err_o     (wake_err_o),
        .link_sel_i     (link_sel_i),
        .link_state_n_o (link_state_n_o)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // vector: {sel[1:0], exp_code[2:0], exp_pme, exp_err}
    localparam int NV = 8;
    localparam logic [6:0] VEC [NV] = '{
        {2'd0, 3'b110, 1'b1, 1'b0},
        {2'd3, 3'b111, 1'b0, 1'b1},
        {2'd1, 3'b101, 1'b1, 1'b0},
        {2'd2, 3'b011, 1'b1, 1'b0},
        {2'd3, 3'b111, 1'b0, 1'b1},
        {2'd2, 3'b011, 1'b1, 1'b0},
        {2'd0, 3'b110, 1'b1, 1'b0},
        {2'd3, 3'b111, 1'b0, 1'b1}
    };

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 warn", 8'(to_turnoff_n_o), 8'd1);
        check("R1 ack", 8'(ack_req_o), 8'd0);
        check("R1 pme", 8'(pme_req_o), 8'd0);
        check("R1 err", 8'(wake_err_o), 8'd0);
        check("R1 link", 8'(link_state_n_o), 8'h7);

        // R6 R7 R8: vector walk
        for (int i = 0; i < NV; i++) begin
            link_sel_i = VEC[i][6:5];
            step();
            check("R6 code", 8'(link_state_n_o), 8'(VEC[i][4:2]));
            wake_n_i = 1'b0;
            step();
            wake_n_i = 1'b1;
            check("R7 pme", 8'(pme_req_o), 8'(VEC[i][1]));
            check("R8 err", 8'(wake_err_o), 8'(VEC[i][0]));
            if (VEC[i][1]) begin
                step();
                check("R7 hold", 8'(pme_req_o), 8'd1);
                pme_accept_i = 1'b1;
                step();
                pme_accept_i = 1'b0;
                check("R7 release", 8'(pme_req_o), 8'd0);
            end else begin
                step();
                check("R8 pulse end", 8'(wake_err_o), 8'd0);
                check("R8 no pme", 8'(pme_req_o), 8'd0);
            end
        end

        // R9: second wake while pending is merged
        link_sel_i = 2'd0;
        step();
        wake_n_i = 1'b0;
        step();
        wake_n_i = 1'b1;
        step();
        wake_n_i = 1'b0;
        step();
        wake_n_i = 1'b1;
        check("R9 pending", 8'(pme_req_o), 8'd1);
        check("R9 no err", 8'(wake_err_o), 8'd0);
        pme_accept_i = 1'b1;
        step();
        pme_accept_i = 1'b0;
        check("R9 single", 8'(pme_req_o), 8'd0);
        repeat (3) step();
        check("R9 stays idle", 8'(pme_req_o), 8'd0);

        // R2 R3 R4: turn-off with delayed consent and stalled accept
        turnoff_msg_i = 1'b1;
        step();
        turnoff_msg_i = 1'b0;
        check("R2 warn", 8'(to_turnoff_n_o), 8'd0);
        check("R3 no ack yet", 8'(ack_req_o), 8'd0);
        repeat (3) step();
        check("R3 waits consent", 8'(ack_req_o), 8'd0);
        turnoff_ok_n_i = 1'b0;
        step();
        turnoff_ok_n_i = 1'b1;
        check("R3 ack", 8'(ack_req_o), 8'd1);
        repeat (3) step();
        check("R4 ack held", 8'(ack_req_o), 8'd1);
        check("R4 warn held", 8'(to_turnoff_n_o), 8'd0);
        ack_accept_i = 1'b1;
        step();
        ack_accept_i = 1'b0;
        check("R4 ack release", 8'(ack_req_o), 8'd0);
        check("R4 warn release", 8'(to_turnoff_n_o), 8'd1);

        // R3: consent already low before warning
        turnoff_ok_n_i = 1'b0;
        step();
        check("R3 no early warn", 8'(to_turnoff_n_o), 8'd1);
        turnoff_msg_i = 1'b1;
        step();
        turnoff_msg_i = 1'b0;
        check("R3 warn first", 8'(to_turnoff_n_o), 8'd0);
        check("R3 ack not same cycle", 8'(ack_req_o), 8'd0);
        step();
        turnoff_ok_n_i = 1'b1;
        check("R3 ack next", 8'(ack_req_o), 8'd1);

        // R5: repeated notice during pending acknowledge
        turnoff_msg_i = 1'b1;
        step();
        turnoff_msg_i = 1'b0;
        ack_accept_i = 1'b1;
        step();
        ack_accept_i = 1'b0;
        turnoff_msg_i = 1'b1;
        check("R5 released", 8'(to_turnoff_n_o), 8'd1);
        step();
        turnoff_msg_i = 1'b0;
        // a fresh notice in idle is honoured; repeat inside NOTIFY is ignored
        check("R2 new notice", 8'(to_turnoff_n_o), 8'd0);
        turnoff_msg_i = 1'b1;
        step();
        turnoff_msg_i = 1'b0;
        turnoff_ok_n_i = 1'b0;
        step();
        turnoff_ok_n_i = 1'b1;
        ack_accept_i = 1'b1;
        step();
        ack_accept_i = 1'b0;
        check("R5 release after repeat", 8'(to_turnoff_n_o), 8'd1);
        repeat (3) step();
        check("R5 stays released", 8'(to_turnoff_n_o), 8'd1);
        check("R5 no ack", 8'(ack_req_o), 8'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule